// File: doc/BRIEF.md
# Framebuffer Write Pixel Packer

This block sits between a pixel source and a framebuffer write port. It takes RGBA pixels of 8 bits per channel, one per handshake. Each pixel becomes one 16-bit framebuffer word, and the layout of that word is chosen by a 2-bit pack mode. Each word leaves as a halfword address/data write. The addresses follow a line pitch that software programs, so an image can be placed inside a wider surface.

Software sets the pack mode, a key byte, an alpha threshold, a pitch field, and the image width and height. Change these settings only between frames. The image must be at least one pixel wide and one line high.

If the image is wider than the pitch, each line is cut down to the pitch. The source still delivers the full width on every line, and the packer consumes the surplus pixels without writing them, so the line framing stays in step. After the last pixel of the last line, the write pointer goes back to halfword 0 for the next frame. Both sides use ready/valid handshakes. When the write side stalls, packing stops and no pixel is lost.

Top module: `fb_pixel_packer`

## Requirements
- R1: Input pixel fields are alpha in `in_pix[31:24]`, red in [23:16], green in [15:8] and blue in [7:0]. In mode 0 the word is {key[7], red[7:3], green[7:3], blue[7:3]}, with bit 15 taken from bit 7 of the key byte.
- R2: In mode 1 the word is {red[7:3], green[7:2], blue[7:3]}.
- R3: In mode 2 the word is {alpha[7:4], red[7:4], green[7:4], blue[7:4]}.
- R4: In mode 3 the word is {A, red[7:3], green[7:3], blue[7:3]}. A is 1 only when alpha is strictly greater than the threshold byte, so an alpha equal to the threshold gives 0.
- R5: A nonzero pitch field F gives a pitch of 8·F bytes, so line L starts at halfword L·4·F. A pitch field of 0 gives a pitch of 2·width bytes, so line L starts at halfword L·width.
- R6: When 2·width is greater than the pitch in bytes, only the first pitch/2 pixels of each line are written. The remaining pixels of that line are still accepted and produce no write.
- R7: Within a line, written pixel c goes to line start + c.
- R8: After height lines have been consumed, the next accepted pixel is written to halfword 0.
- R9: While `out_valid` is high and `out_ready` is low, address and data stay unchanged. `in_ready` drops only in that state. Every written pixel leaves exactly once, in input order.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, and the first write goes to halfword 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Pack mode 0..3 |
| cfg_key | input | 8 | Key byte; bit 7 feeds word bit 15 in mode 0 |
| cfg_thresh | input | 8 | Alpha threshold for mode 3 |
| cfg_stride | input | STRIDE_W | Pitch field in units of 8 bytes; 0 = 2·width |
| cfg_width | input | DIM_W | Pixels per input line |
| cfg_height | input | DIM_W | Lines per frame |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel accepted when high with valid |
| in_pix | input | 32 | Pixel {A,R,G,B} |
| out_valid | output | 1 | Write valid |
| out_ready | input | 1 | Write side ready |
| out_addr | output | ADDR_W | Halfword address |
| out_data | output | 16 | Packed word |

## Verification
The bench aims at the threshold boundary: an alpha equal to the threshold must give 0. A design that compared with greater-or-equal would set bit 15 on that pixel. It also checks the key bit with key bytes just above and below 0x80. It runs pitch fields of zero, pitches wider than the line, and pitches narrower than the line. With a narrow pitch, a design that failed to clip would write into the next line's space, and one that did not consume the surplus pixels would shift every later line. Frames run back to back to catch a pointer that fails to wrap to zero. Random output stalls would reveal a dropped word, a duplicated word, or a word that changes while held.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [1:0] {
    PK_KEY555  = 2'd0,
    PK_RGB565  = 2'd1,
    PK_ARGB444 = 2'd2,
    PK_THR555  = 2'd3
  } pack_mode_e;

  // Pixel layout: {alpha, red, green, blue}, 8 bits each
  function automatic logic [15:0] pack_word(input pack_mode_e m,
                                            input logic [7:0] key,
                                            input logic [7:0] thr,
                                            input logic [31:0] pix);
    logic [7:0] a, r, g, b;
    logic [15:0] w;
    a = pix[31:24];
    r = pix[23:16];
    g = pix[15:8];
    b = pix[7:0];
    unique case (m)
      PK_KEY555:  w = {key[7], r[7:3], g[7:3], b[7:3]};
      PK_RGB565:  w = {r[7:3], g[7:2], b[7:3]};
      PK_ARGB444: w = {a[7:4], r[7:4], g[7:4], b[7:4]};
      default:    w = {(a > thr), r[7:3], g[7:3], b[7:3]};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fbp_pack.sv
module fbp_pack
  import fbp_pkg::*;
(
  input  logic [1:0]  mode,
  input  logic [7:0]  key,
  input  logic [7:0]  thr,
  input  logic [31:0] pix,
  output logic [15:0] word
);
  pack_mode_e mode_e;
  assign mode_e = pack_mode_e'(mode);
  assign word   = pack_word(mode_e, key, thr, pix);
endmodule

// File: rtl/fbp_addr_gen.sv
module fbp_addr_gen #(
  parameter int DIM_W    = 10,
  parameter int STRIDE_W = 6,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [DIM_W-1:0]    width,
  input  logic [DIM_W-1:0]    height,
  input  logic [STRIDE_W-1:0] stride_field,
  output logic                discard,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic                line_end,
  output logic                frame_end
);
  localparam int SPAN_W = ((STRIDE_W + 2) > DIM_W) ? (STRIDE_W + 2) : DIM_W;

  // Line pitch in halfwords
  function automatic logic [SPAN_W-1:0] line_span(input logic [DIM_W-1:0] w,
                                                  input logic [STRIDE_W-1:0] f);
    if (f == '0) return SPAN_W'(w);
    return SPAN_W'({f, 2'b00});
  endfunction

  // Pixels actually written per line
  function automatic logic [SPAN_W-1:0] eff_cols(input logic [DIM_W-1:0] w,
                                                 input logic [STRIDE_W-1:0] f);
    logic [SPAN_W-1:0] s;
    s = line_span(w, f);
    return (SPAN_W'(w) > s) ? s : SPAN_W'(w);
  endfunction

  logic [DIM_W-1:0]  col_q, line_q;
  logic [ADDR_W-1:0] base_q;
  logic [SPAN_W-1:0] span, eff;
  logic              last_col, last_line;

  assign span      = line_span(width, stride_field);
  assign eff       = eff_cols(width, stride_field);
  assign discard   = SPAN_W'(col_q) >= eff;
  assign wr_addr   = base_q + ADDR_W'(col_q);
  assign last_col  = (col_q == width - DIM_W'(1));
  assign last_line = (line_q == height - DIM_W'(1));
  assign line_end  = step && last_col;
  assign frame_end = line_end && last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
      base_q <= '0;
    end else if (step) begin
      if (last_col) begin
        col_q <= '0;
        if (last_line) begin
          line_q <= '0;
          base_q <= '0;
        end else begin
          line_q <= line_q + DIM_W'(1);
          base_q <= base_q + ADDR_W'(span);
        end
      end else begin
        col_q <= col_q + DIM_W'(1);
      end
    end
  end

  // R6: column counter never runs past the input line width
  p_col_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (width != '0) |-> (col_q < width));

  // R8: a frame end returns the pointer to halfword 0
  p_frame_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (wr_addr == '0));

endmodule

// File: rtl/fbp_out_stage.sv
module fbp_out_stage #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              out_ready,
  output logic              can_load,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= ld_addr;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a held word does not change while stalled
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));

  // R9: never overwrite an undrained word
  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));

endmodule

// File: rtl/fb_pixel_packer.sv
module fb_pixel_packer #(
  parameter int DIM_W    = 10,
  parameter int STRIDE_W = 6,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic [7:0]          cfg_key,
  input  logic [7:0]          cfg_thresh,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [DIM_W-1:0]    cfg_width,
  input  logic [DIM_W-1:0]    cfg_height,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         in_pix,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [15:0]         out_data
);
  localparam int WORD_W = 16;

  logic              accept, discard, wr_load, can_load;
  logic              line_end, frame_end;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] packed_word;

  assign in_ready = can_load || discard;
  assign accept   = in_valid && in_ready;
  assign wr_load  = accept && !discard;

  fbp_pack u_pack (
    .mode (cfg_mode),
    .key  (cfg_key),
    .thr  (cfg_thresh),
    .pix  (in_pix),
    .word (packed_word)
  );

  fbp_addr_gen #(.DIM_W(DIM_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (accept),
    .width        (cfg_width),
    .height       (cfg_height),
    .stride_field (cfg_stride),
    .discard      (discard),
    .wr_addr      (wr_addr),
    .line_end     (line_end),
    .frame_end    (frame_end)
  );

  fbp_out_stage #(.DATA_W(WORD_W), .ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_load),
    .ld_addr   (wr_addr),
    .ld_data   (packed_word),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_data  (out_data)
  );

  // R9: input backpressure only while a word is held
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (out_valid && !out_ready));

  // R1: key bit follows key byte bit 7 in mode 0
  p_key_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && cfg_mode == 2'd0) |=> (out_data[15] == $past(cfg_key[7])));

  // R4: strict alpha threshold in mode 3
  p_alpha_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && cfg_mode == 2'd3) |=>
      (out_data[15] == ($past(in_pix[31:24]) > $past(cfg_thresh))));

  // R6: a discarded pixel creates no new write
  p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && discard) |=> (out_valid == $past(out_valid && !out_ready)));

endmodule

// File: tb/fb_pixel_packer_tb_top.sv
`timescale 1ns/1ps
module fb_pixel_packer_tb_top;
  localparam int DIM_W = 10, STRIDE_W = 6, ADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [7:0] cfg_key = '0, cfg_thresh = '0;
  logic [STRIDE_W-1:0] cfg_stride = '0;
  logic [DIM_W-1:0] cfg_width = 10'd1, cfg_height = 10'd1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [31:0] in_pix = '0;
  logic [ADDR_W-1:0] out_addr;
  logic [15:0] out_data;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [31:0] pix_mem [0:1023];
  int exp_addr [0:1023];
  int exp_data [0:1023];
  int exp_col  [0:1023];
  int n_exp;

  always #2 clk = ~clk;

  fb_pixel_packer #(.DIM_W(DIM_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_key(cfg_key),
    .cfg_thresh(cfg_thresh), .cfg_stride(cfg_stride), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // Independent packing model: fields built by division and shifts
  function automatic int ref_word(int mode, int key, int thr, logic [31:0] p);
    int a, r, g, b;
    a = p[31:24]; r = p[23:16]; g = p[15:8]; b = p[7:0];
    case (mode)
      0: return ((key / 128) * 32768) + (r / 8) * 1024 + (g / 8) * 32 + (b / 8);
      1: return (r / 8) * 2048 + (g / 4) * 32 + (b / 8);
      2: return (a / 16) * 4096 + (r / 16) * 256 + (g / 16) * 16 + (b / 16);
      default: return ((a > thr) ? 32768 : 0) + (r / 8) * 1024 + (g / 8) * 32 + (b / 8);
    endcase
  endfunction

  function automatic string mode_tag(int mode);
    case (mode)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_frame(input int mode, key, thr, field, w, h, nfr, input bit preset);
    int pitch_b, span, effw, pi, oi, guard;
    bit stall_seen;
    int held_a, held_d;
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_key = 8'(key); cfg_thresh = 8'(thr);
    cfg_stride = STRIDE_W'(field); cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
    pitch_b = (field == 0) ? w * 2 : field * 8;
    span = pitch_b / 2;
    effw = (w * 2 > pitch_b) ? pitch_b / 2 : w;
    for (int f = 0; f < nfr; f++) begin
      if (!preset || f > 0)
        for (int i = 0; i < w * h; i++) pix_mem[i] = $urandom;
      n_exp = 0;
      for (int l = 0; l < h; l++)
        for (int c = 0; c < effw; c++) begin
          exp_addr[n_exp] = l * span + c;
          exp_data[n_exp] = ref_word(mode, key, thr, pix_mem[l * w + c]);
          exp_col[n_exp]  = c;
          n_exp++;
        end
      pi = 0; oi = 0; guard = 0; stall_seen = 0; held_a = 0; held_d = 0;
      while ((pi < w * h || oi < n_exp) && guard < 20000) begin
        @(negedge clk);
        guard++;
        if (stall_seen)
          chk(out_valid && int'(out_addr) == held_a && int'(out_data) == held_d,
              "R9 held word", int'(out_data), held_d);
        in_valid  = (pi < w * h) && ($urandom % 4 != 0);
        in_pix    = pix_mem[pi];
        out_ready = ($urandom % 10) < 7;
        #1;
        if (out_valid && out_ready) begin
          if (oi >= n_exp) chk(0, "R6 extra write", int'(out_addr), -1);
          else begin
            string at;
            if (exp_addr[oi] == 0 && f > 0) at = "R8 address";
            else if (exp_col[oi] == 0) at = "R5 address";
            else at = "R7 address";
            chk(int'(out_addr) == exp_addr[oi], at, int'(out_addr), exp_addr[oi]);
            chk(int'(out_data) == exp_data[oi], mode_tag(mode), int'(out_data), exp_data[oi]);
          end
          oi++;
        end
        stall_seen = out_valid && !out_ready;
        held_a = int'(out_addr); held_d = int'(out_data);
        if (in_valid && in_ready) pi++;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      chk(oi == n_exp, "R6 write count", oi, n_exp);
      repeat (2) @(negedge clk);
      chk(!out_valid, "R9 no stray write", int'(out_valid), 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R10 out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R10 in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 key bit both ways, first write at address 0 (R10)
    run_frame(0, 8'h80, 0, 0, 4, 2, 1, 0);
    run_frame(0, 8'h7F, 0, 0, 4, 2, 1, 0);
    // R4 threshold boundary
    pix_mem[0] = 32'h80_FF_00_FF; pix_mem[1] = 32'h81_00_FF_00;
    pix_mem[2] = 32'h7F_12_34_56; pix_mem[3] = 32'hFF_AB_CD_EF;
    run_frame(3, 0, 8'h80, 0, 4, 1, 1, 1);
    // R2 extreme channels
    pix_mem[0] = 32'h00_FF_00_FF; pix_mem[1] = 32'h00_00_FF_00;
    pix_mem[2] = 32'h00_07_03_07; pix_mem[3] = 32'h00_08_04_08;
    run_frame(1, 0, 0, 0, 4, 1, 1, 1);
    // R5 wide pitch, R3 packing
    run_frame(1, 0, 0, 3, 5, 3, 1, 0);
    run_frame(2, 0, 0, 4, 7, 3, 1, 0);
    // R6 clip: width 10, pitch field 2 gives 8 written pixels
    run_frame(2, 0, 0, 2, 10, 3, 1, 0);
    // R8 back-to-back frames
    run_frame(3, 0, 8'h40, 1, 6, 2, 3, 0);
    // random configurations
    for (int k = 0; k < 24; k++)
      run_frame($urandom % 4, $urandom % 256, $urandom % 256, $urandom % 8,
                1 + $urandom % 20, 1 + $urandom % 6, 1 + $urandom % 2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule